// File: doc/BRIEF.md
# Host Interrupt Aggregation Controller

This block gathers single-cycle event pulses from a set of on-chip sources and from a bank of general-purpose pins. It records them in a top-level status register and drives one interrupt request line toward a host processor. The pin bank has its own per-pin status register. Its events reach the top level through one reserved status bit, so the pin status works as a second level of status.

Software reaches the block through a plain register port: an address, write data, a write strobe and combinational read data. A control register holds three settings: a master enable, the output type (level or pulse) and the active polarity. A source-enable register selects which top-level status bits may raise the request. Status bits are cleared by writing ones to them, and they keep recording events whatever the enables are set to.

Register map (word addresses): 0 control, 1 source enable, 2 top-level status, 3 pin status. Any other address reads as zero and ignores writes.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every register reads zero and `irq_o` is 0.
- R2: Control register bits are: bit 0 master enable, bit 1 output type (0 level, 1 pulse), bit 2 polarity (0 active low, 1 active high). Only these three bits are kept, and they read back in the same positions.
- R3: While the master enable is 0, `irq_o` is 0 whatever the status, the source enables, the type and the polarity are.
- R4: A pulse on `src_evt[i]` sets top-level status bit i at the next clock edge. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If an event and a clear reach the same bit in the same cycle, the bit stays set.
- R5: Status bits are recorded and held whether or not the master enable or the matching source-enable bit is set.
- R6: A pulse on `gpio_evt[p]` sets pin status bit p at address 3, which is cleared by writing 1. Top-level bit `GPIO_BIT` (default 8) is set only by a pin event whose pin status bit is currently 0. `src_evt[GPIO_BIT]` has no effect.
- R7: In level mode, `irq_o` shows the active level in the same cycle in which any top-level status bit that is also enabled holds 1. It shows the inactive level in all other cycles.
- R8: In pulse mode, `irq_o` is active for exactly `PULSE_CYC` cycles. The pulse starts one cycle after the set of pending enabled status bits goes from empty to non-empty. No new pulse starts while that set stays non-empty.
- R9: The source-enable register (address 1, one bit per top-level status bit) affects only the request output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt | input | NUM_SRC | Single-cycle event pulses from the sources |
| gpio_evt | input | GPIO_W | Single-cycle event pulses from the pins |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_we | input | 1 | Write strobe, acts at the clock edge |
| reg_rdata | output | DATA_W | Combinational read data for `reg_addr` |
| irq_o | output | 1 | Interrupt request to the host |

## Verification
An event or a write presented before a clock edge shows in the read data and in the level-mode request just after that same edge. A pulse-mode request rises one edge later and lasts `PULSE_CYC` cycles. The bench drives its inputs at the falling edge and steps its reference model at each rising edge. It compares read data in the low phase before the edge and compares `irq_o` at the following falling edge, so each result is sampled in the cycle it is due. Directed sequences then count the pulse width, and they probe the collisions between a set and a clear and the rule that both status levels must be cleared before a pin can interrupt again.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int NUM_SRC   = 12,
  parameter int GPIO_W    = 24,
  parameter int GPIO_BIT  = 8,
  parameter int PULSE_CYC = 5,
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_SRC-1:0] src_evt,
  input  logic [GPIO_W-1:0]  gpio_evt,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  input  logic              reg_we,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic              irq_o
);
  localparam int CNT_W = $clog2(PULSE_CYC + 1);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_GPIO = ADDR_W'(3);
  localparam logic [NUM_SRC-1:0] GMASK = {{(NUM_SRC-1){1'b0}}, 1'b1} << GPIO_BIT;

  logic [2:0]         ctrl_q;
  logic [NUM_SRC-1:0] en_q, st_q, set_v, clr_v;
  logic [GPIO_W-1:0]  gst_q, gclr_v;
  logic               pend, pend_d_q, act;
  logic [CNT_W-1:0]   cnt_q;

  wire gen   = ctrl_q[0];
  wire etype = ctrl_q[1];
  wire pol   = ctrl_q[2];

  wire wr_ctrl = reg_we && (reg_addr == A_CTRL);
  wire wr_en   = reg_we && (reg_addr == A_EN);
  wire wr_st   = reg_we && (reg_addr == A_STAT);
  wire wr_gst  = reg_we && (reg_addr == A_GPIO);

  wire gpio_new = |(gpio_evt & ~gst_q);

  assign set_v  = (src_evt & ~GMASK) | (gpio_new ? GMASK : '0);
  assign clr_v  = wr_st  ? reg_wdata[NUM_SRC-1:0] : '0;
  assign gclr_v = wr_gst ? reg_wdata[GPIO_W-1:0]  : '0;
  assign pend   = |(st_q & en_q);

  logic unused_wbits;
  assign unused_wbits = ^reg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      en_q     <= '0;
      st_q     <= '0;
      gst_q    <= '0;
      pend_d_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= reg_wdata[2:0];
      if (wr_en)   en_q   <= reg_wdata[NUM_SRC-1:0];
      st_q     <= (st_q & ~clr_v) | set_v;
      gst_q    <= (gst_q & ~gclr_v) | gpio_evt;
      pend_d_q <= pend;
      if (pend && !pend_d_q)  cnt_q <= CNT_W'(PULSE_CYC);
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata[2:0]         = ctrl_q;
      A_EN:    reg_rdata[NUM_SRC-1:0] = en_q;
      A_STAT:  reg_rdata[NUM_SRC-1:0] = st_q;
      A_GPIO:  reg_rdata[GPIO_W-1:0]  = gst_q;
      default: reg_rdata = '0;
    endcase
  end

  assign act   = etype ? (cnt_q != '0) : pend;
  assign irq_o = gen & (pol ? act : ~act);
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter int NUM_SRC  = 12,
  parameter int GPIO_W   = 24,
  parameter int GPIO_BIT = 8,
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_SRC-1:0] src_evt,
  input logic [GPIO_W-1:0]  gpio_evt,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [DATA_W-1:0]  reg_wdata,
  input logic              reg_we,
  input logic              irq_o,
  input logic [2:0]         ctrl_q,
  input logic [NUM_SRC-1:0] st_q,
  input logic [GPIO_W-1:0]  gst_q,
  input logic              pend
);
  localparam logic [NUM_SRC-1:0] NONG = ~({{(NUM_SRC-1){1'b0}}, 1'b1} << GPIO_BIT);

  assert_low_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[0] |-> !irq_o);

  assert_evt_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_evt & NONG) != '0) |=> ((st_q & $past(src_evt & NONG)) == $past(src_evt & NONG)));

  assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_W'(2)) |=>
      ((st_q & $past(reg_wdata[NUM_SRC-1:0]) & ~$past(src_evt) & NONG) == '0));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == ADDR_W'(2)) |=> ((st_q & $past(st_q)) == $past(st_q)));

  assert_gpio_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((gpio_evt & ~gst_q) != '0) |=> st_q[GPIO_BIT]);

  assert_pulse_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[0] && ctrl_q[1] && pend && !$past(pend) && !reg_we) |=> (irq_o == ctrl_q[2]));
endmodule

bind irq_aggregator irq_aggregator_chk #(
  .NUM_SRC(NUM_SRC), .GPIO_W(GPIO_W), .GPIO_BIT(GPIO_BIT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .gpio_evt(gpio_evt), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_we(reg_we), .irq_o(irq_o), .ctrl_q(ctrl_q), .st_q(st_q),
  .gst_q(gst_q), .pend(pend)
);

// File: tb/sim_irq_aggregator.sv
module sim_irq_aggregator;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 12, GW = 24, GB = 8, PC = 5, AW = 3, DW = 32;

  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0, irq_o;
  logic [NS-1:0] src_evt = '0;
  logic [GW-1:0] gpio_evt = '0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0, reg_rdata;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [2:0] m_ctrl;
  logic [NS-1:0] m_en, m_st;
  logic [GW-1:0] m_gst;
  logic m_pd;
  int m_cnt;

  irq_aggregator #(.NUM_SRC(NS), .GPIO_W(GW), .GPIO_BIT(GB), .PULSE_CYC(PC),
                   .ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .gpio_evt(gpio_evt), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata), .irq_o(irq_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] exp_rd(input logic [AW-1:0] a);
    case (a)
      0: return DW'(m_ctrl);
      1: return DW'(m_en);
      2: return DW'(m_st);
      3: return DW'(m_gst);
      default: return '0;
    endcase
  endfunction

  function automatic logic exp_irq();
    logic act;
    act = m_ctrl[1] ? (m_cnt != 0) : (|(m_st & m_en));
    return m_ctrl[0] & (m_ctrl[2] ? act : ~act);
  endfunction

  task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string rd_tag(input logic [AW-1:0] a);
    case (a)
      0: return "R2";
      1: return "R9";
      2: return "R4";
      3: return "R6";
      default: return "R2";
    endcase
  endfunction

  task automatic tick();
    logic [NS-1:0] setv, clrv, nst, nen;
    logic [GW-1:0] ngst, gclr;
    logic [2:0] nctrl;
    logic pend;
    int ncnt;
    setv = src_evt & ~(NS'(1) << GB);
    if (|(gpio_evt & ~m_gst)) setv[GB] = 1'b1;
    clrv = (reg_we && reg_addr == 2) ? reg_wdata[NS-1:0] : '0;
    gclr = (reg_we && reg_addr == 3) ? reg_wdata[GW-1:0] : '0;
    nst  = (m_st & ~clrv) | setv;
    ngst = (m_gst & ~gclr) | gpio_evt;
    nctrl = (reg_we && reg_addr == 0) ? reg_wdata[2:0] : m_ctrl;
    nen   = (reg_we && reg_addr == 1) ? reg_wdata[NS-1:0] : m_en;
    pend = |(m_st & m_en);
    ncnt = (pend && !m_pd) ? PC : (m_cnt > 0 ? m_cnt - 1 : 0);
    @(posedge clk);
    m_st = nst; m_gst = ngst; m_ctrl = nctrl; m_en = nen; m_pd = pend; m_cnt = ncnt;
    @(negedge clk);
    chk(DW'(irq_o), DW'(exp_irq()), !m_ctrl[0] ? "R3" : (m_ctrl[1] ? "R8" : "R7"));
  endtask

  task automatic drv(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input logic [NS-1:0] s, input logic [GW-1:0] g);
    reg_we = we; reg_addr = a; reg_wdata = d; src_evt = s; gpio_evt = g;
  endtask

  task automatic idle();
    drv(1'b0, '0, '0, '0, '0);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    idle(); reg_addr = a; #1;
    chk(reg_rdata, exp, tag);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    drv(1'b1, a, d, '0, '0); tick(); idle();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int pw;
    void'($urandom(32'd20240611));
    m_ctrl = '0; m_en = '0; m_st = '0; m_gst = '0; m_pd = 1'b0; m_cnt = 0;
    repeat (3) @(negedge clk);
    chk(DW'(irq_o), 0, "R1");
    rst_n = 1'b1;
    for (int a = 0; a < 4; a++) rd(AW'(a), '0, "R1");

    for (int i = 0; i < 4000; i++) begin
      logic [AW-1:0] a;
      a = AW'($urandom_range(0, 5));
      reg_addr = a; reg_we = 1'b0; #1;
      chk(reg_rdata, exp_rd(a), rd_tag(a));
      reg_we    = ($urandom_range(0, 3) == 0);
      reg_wdata = $urandom;
      src_evt   = NS'($urandom & $urandom & $urandom);
      gpio_evt  = GW'($urandom & $urandom & $urandom & $urandom);
      tick();
    end
    idle();

    wr(0, 0); wr(1, '1); wr(2, '1); wr(3, '1); wr(2, '1);
    drv(1'b0, 0, 0, NS'(1), '0); tick(); idle();
    rd(2, 32'h1, "R5");
    chk(DW'(irq_o), 0, "R3");

    drv(1'b1, 2, 32'h1, NS'(1), '0); tick(); idle();
    rd(2, 32'h1, "R4");
    wr(2, 32'h0);
    rd(2, 32'h1, "R4");
    wr(2, 32'h1);
    rd(2, 32'h0, "R4");

    drv(1'b0, 0, 0, NS'(1) << GB, '0); tick(); idle();
    rd(2, 32'h0, "R6");
    drv(1'b0, 0, 0, '0, GW'(1) << 3); tick(); idle();
    rd(2, 32'h100, "R6");
    rd(3, 32'h8, "R6");
    wr(2, 32'h100);
    drv(1'b0, 0, 0, '0, GW'(1) << 3); tick(); idle();
    rd(2, 32'h0, "R6");
    wr(3, 32'h8);
    drv(1'b0, 0, 0, '0, GW'(1) << 3); tick(); idle();
    rd(2, 32'h100, "R6");
    wr(2, '1); wr(3, '1);

    wr(1, 32'h1); wr(0, 32'h1);
    chk(DW'(irq_o), 1, "R7");
    drv(1'b0, 0, 0, NS'(2), '0); tick(); idle();
    chk(DW'(irq_o), 1, "R9");
    drv(1'b0, 0, 0, NS'(1), '0); tick(); idle();
    chk(DW'(irq_o), 0, "R7");
    wr(2, '1);
    chk(DW'(irq_o), 1, "R7");

    wr(1, 32'h3); wr(0, 32'h7);
    repeat (PC + 2) tick();
    drv(1'b0, 0, 0, NS'(1), '0); tick(); idle();
    chk(DW'(irq_o), 0, "R8");
    pw = 0;
    for (int k = 0; k < PC + 4; k++) begin tick(); if (irq_o) pw++; end
    chk(DW'(pw), DW'(PC), "R8");
    drv(1'b0, 0, 0, NS'(2), '0); tick(); idle();
    pw = 0;
    for (int k = 0; k < PC + 4; k++) begin tick(); if (irq_o) pw++; end
    chk(DW'(pw), 0, "R8");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule